// File: doc/BRIEF.md
# Push-Button Accumulator Calculator

A small clocked calculator that keeps a 16-bit running value in an accumulator and shows that value on 16 LED outputs. The user sets a 16-bit operand on the switches and chooses one of eight operations with three selector buttons. A press of the step button then folds the switch value into the accumulator. The accumulator, widened to 32 bits with its sign, is the first operand. The switches, widened the same way, are the second. The low 16 bits of the 32-bit result are written back.

The step button goes through a registered rising-edge detector, so one press causes exactly one update however long the button is held. The selector buttons and switches are read as they stand in the cycle of that update. A separate clear button sets the accumulator to zero on the next clock edge and wins over a step in the same cycle. The datapath uses sparse 4-bit operation codes. Codes that no selection produces fall back to addition.

Top module: `accum_calc`

## Requirements
- R1: `led_out` always shows the current 16-bit accumulator value and changes only on a clock edge.
- R2: While `clr_btn` is high at a rising clock edge, the accumulator becomes 0x0000 at that edge.
- R3: If a clear and a step update fall in the same cycle, the clear wins and the accumulator becomes 0x0000.
- R4: Each 0-to-1 transition of `step_btn` updates the accumulator exactly once, two clock edges after the button is first seen high. Holding the button high for any number of cycles causes no further updates.
- R5: Both operands are sign-extended from 16 to 32 bits before the operation, and the low 16 bits of the result are kept. Signed comparison and arithmetic right shift therefore treat bit 15 as the sign.
- R6: The selector code {pick_hi,pick_mid,pick_lo} = 000 adds the switches to the accumulator, and 001 subtracts them (accumulator minus switches), both modulo 2^16.
- R7: Code 010 gives bitwise AND, 011 gives bitwise OR and 100 gives bitwise XOR of the accumulator and the switches.
- R8: Code 101 gives 0x0001 when the accumulator is less than the switches as signed 16-bit numbers, and 0x0000 otherwise.
- R9: Code 110 shifts the accumulator left, and code 111 shifts it right arithmetically. The shift amount is bits 4:0 of the switches, from 0 to 31. A left shift of 16 or more leaves 0x0000, and an arithmetic right shift of 16 or more leaves all copies of the sign bit.
- R10: Changes to the selector buttons or switches while no update happens leave `led_out` unchanged.
- R11: From a cleared state, this sequence gives the values shown: OR 0x1234 gives 0x1234, AND 0x0ff0 gives 0x0230, add 0x324f gives 0x347f, subtract 0x2d31 gives 0x074e, XOR 0xffff gives 0xf8b1, less-than 0x7346 gives 0x0001, and less-than 0xffff gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr_btn | input | 1 | Synchronous clear of the accumulator, active high |
| step_btn | input | 1 | Step button; its rising edge triggers one update |
| pick_hi | input | 1 | Operation selector, most significant bit |
| pick_mid | input | 1 | Operation selector, middle bit |
| pick_lo | input | 1 | Operation selector, least significant bit |
| sw_in | input | 16 | Second operand from the switches |
| led_out | output | 16 | Current accumulator value |

## Verification
The bench holds the step button for dozens of cycles to check that only one update occurs. A level-sensitive enable would add the operand again on every cycle. It raises clear and step together and expects zero; an update that won the tie would leave a sum. It uses negative accumulators and shift amounts of 16 and above to expose a missing sign extension: a zero-filled operand would return 0 instead of 0xffff from an arithmetic right shift and would give the wrong answer for a signed less-than. It also changes the selectors between presses and expects the LEDs to hold, which catches a design that registers a new result every cycle.

// File: rtl/calc_pkg.sv
package calc_pkg;
  // Datapath width of the arithmetic unit and register width of the accumulator.
  localparam int unsigned DP_W  = 32;
  localparam int unsigned ACC_W = 16;
  localparam int unsigned SEL_W = 3;

  // Sparse operation codes; unused codes fall back to addition.
  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_SRL = 4'b1000,
    OP_SLL = 4'b1001,
    OP_SRA = 4'b1010,
    OP_XOR = 4'b1101
  } op_code_t;
endpackage

// File: rtl/calc_opsel.sv
module calc_opsel
  import calc_pkg::*;
(
  input  logic [SEL_W-1:0] pick,
  output op_code_t         code
);
  // Three-button code to sparse operation code.
  always_comb begin
    case (pick)
      3'b000:  code = OP_ADD;
      3'b001:  code = OP_SUB;
      3'b010:  code = OP_AND;
      3'b011:  code = OP_OR;
      3'b100:  code = OP_XOR;
      3'b101:  code = OP_SLT;
      3'b110:  code = OP_SLL;
      default: code = OP_SRA;
    endcase
  end
endmodule

// File: rtl/calc_alu.sv
module calc_alu
  import calc_pkg::*;
#(
  parameter int unsigned W = DP_W
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  op_code_t     code,
  output logic [W-1:0] res
);
  localparam int unsigned SH_W = $clog2(W);

  logic [SH_W-1:0] shamt;
  logic            lt_signed;

  assign shamt     = rhs[SH_W-1:0];
  assign lt_signed = $signed(lhs) < $signed(rhs);

  always_comb begin
    case (code)
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      OP_SUB:  res = lhs - rhs;
      OP_SLT:  res = {{(W-1){1'b0}}, lt_signed};
      OP_SRL:  res = lhs >> shamt;
      OP_SLL:  res = lhs << shamt;
      OP_SRA:  res = $unsigned($signed(lhs) >>> shamt);
      default: res = lhs + rhs;
    endcase
  end
endmodule

// File: rtl/calc_edge.sv
module calc_edge (
  input  logic clk,
  input  logic btn,
  output logic fire
);
  // Register the button, then flag the cycle where it is newly high.
  logic btn_q;
  logic btn_qq;

  always_ff @(posedge clk) begin
    btn_q  <= btn;
    btn_qq <= btn_q;
  end

  assign fire = btn_q & ~btn_qq;
endmodule

// File: rtl/accum_calc.sv
module accum_calc
  import calc_pkg::*;
#(
  parameter int unsigned AW = ACC_W,
  parameter int unsigned DW = DP_W
) (
  input  logic          clk,
  input  logic          clr_btn,
  input  logic          step_btn,
  input  logic          pick_hi,
  input  logic          pick_mid,
  input  logic          pick_lo,
  input  logic [AW-1:0] sw_in,
  output logic [AW-1:0] led_out
);
  localparam int unsigned EXT_W = DW - AW;

  logic [AW-1:0] acc_q;
  logic          step_fire;
  op_code_t      op_code;
  logic [DW-1:0] opnd_a;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] alu_res;
  logic          unused_hi;

  calc_edge u_edge (
    .clk  (clk),
    .btn  (step_btn),
    .fire (step_fire)
  );

  calc_opsel u_sel (
    .pick ({pick_hi, pick_mid, pick_lo}),
    .code (op_code)
  );

  // Sign-extend both operands to the datapath width.
  assign opnd_a = {{EXT_W{acc_q[AW-1]}}, acc_q};
  assign opnd_b = {{EXT_W{sw_in[AW-1]}}, sw_in};

  calc_alu #(.W(DW)) u_alu (
    .lhs  (opnd_a),
    .rhs  (opnd_b),
    .code (op_code),
    .res  (alu_res)
  );

  assign unused_hi = ^alu_res[DW-1:AW];

  // Clear has priority over a step in the same cycle.
  always_ff @(posedge clk) begin
    if (clr_btn)        acc_q <= '0;
    else if (step_fire) acc_q <= alu_res[AW-1:0];
  end

  assign led_out = acc_q;
endmodule

// File: rtl/calc_checker.sv
module calc_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          clr,
  input logic          fire,
  input logic [2:0]    sel,
  input logic [AW-1:0] sw,
  input logic [AW-1:0] led,
  input logic [AW-1:0] res_lo
);
  // Checks start only after the first clear has defined the state.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (led == '0));

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!armed)
    (clr && fire) |=> (led == '0));

  a_r4_single_fire: assert property (@(posedge clk) disable iff (!armed)
    fire |=> !fire);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !fire) |=> $stable(led));

  a_r5_load_result: assert property (@(posedge clk) disable iff (!armed)
    (!clr && fire) |=> (led == $past(res_lo)));

  a_r6_add_path: assert property (@(posedge clk) disable iff (!armed)
    (!clr && fire && sel == 3'b000) |=> (led == AW'($past(led) + $past(sw))));

  a_r7_and_path: assert property (@(posedge clk) disable iff (!armed)
    (!clr && fire && sel == 3'b010) |=> (led == ($past(led) & $past(sw))));
endmodule

bind accum_calc calc_checker #(.AW(AW)) u_chk (
  .clk    (clk),
  .clr    (clr_btn),
  .fire   (step_fire),
  .sel    ({pick_hi, pick_mid, pick_lo}),
  .sw     (sw_in),
  .led    (led_out),
  .res_lo (alu_res[AW-1:0])
);

// File: tb/accum_calc_tb.sv
`timescale 1ns/1ps
module accum_calc_tb;
  logic        clk = 1'b0;
  logic        clr_btn = 1'b0;
  logic        step_btn = 1'b0;
  logic        pick_hi = 1'b0;
  logic        pick_mid = 1'b0;
  logic        pick_lo = 1'b0;
  logic [15:0] sw_in = 16'h0000;
  logic [15:0] led_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  accum_calc u_dut (
    .clk      (clk),
    .clr_btn  (clr_btn),
    .step_btn (step_btn),
    .pick_hi  (pick_hi),
    .pick_mid (pick_mid),
    .pick_lo  (pick_lo),
    .sw_in    (sw_in),
    .led_out  (led_out)
  );

  task automatic check(input string req, input logic [15:0] exp);
    n_checks++;
    if (led_out !== exp) begin
      n_fail++;
      $display("FAIL %s: led_out=%h expected %h", req, led_out, exp);
    end
  endtask

  task automatic clear_acc();
    @(negedge clk) clr_btn = 1'b1;
    repeat (2) @(negedge clk);
    clr_btn = 1'b0;
    @(negedge clk);
  endtask

  // Set selector and switches, press step for 3 cycles, release.
  task automatic press(input logic [2:0] sel, input logic [15:0] v);
    @(negedge clk);
    {pick_hi, pick_mid, pick_lo} = sel;
    sw_in = v;
    step_btn = 1'b1;
    repeat (3) @(negedge clk);
    step_btn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_acc();
    check("R2 clear", 16'h0000);
    check("R1 led shows acc", 16'h0000);
  endtask

  task automatic t_sequence();
    clear_acc();
    press(3'b011, 16'h1234); check("R11/R7 OR",  16'h1234);
    press(3'b010, 16'h0ff0); check("R11/R7 AND", 16'h0230);
    press(3'b000, 16'h324f); check("R11/R6 add", 16'h347f);
    press(3'b001, 16'h2d31); check("R11/R6 sub", 16'h074e);
    press(3'b100, 16'hffff); check("R11/R7 XOR", 16'hf8b1);
    press(3'b101, 16'h7346); check("R11/R8 lt true (R5 signed)", 16'h0001);
    press(3'b101, 16'hffff); check("R11/R8 lt false", 16'h0000);
  endtask

  task automatic t_hold();
    clear_acc();
    @(negedge clk);
    {pick_hi, pick_mid, pick_lo} = 3'b000;
    sw_in = 16'h0001;
    step_btn = 1'b1;
    repeat (60) @(negedge clk);
    check("R4 single update while held", 16'h0001);
    step_btn = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 no update on release", 16'h0001);
    press(3'b000, 16'h0001);
    check("R4 second press updates once", 16'h0002);
  endtask

  task automatic t_priority();
    clear_acc();
    press(3'b011, 16'h00f0);
    @(negedge clk);
    {pick_hi, pick_mid, pick_lo} = 3'b000;
    sw_in = 16'h0005;
    clr_btn = 1'b1;
    step_btn = 1'b1;
    repeat (3) @(negedge clk);
    clr_btn = 1'b0;
    step_btn = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 clear beats step", 16'h0000);
  endtask

  task automatic t_shifts();
    clear_acc();
    press(3'b011, 16'h0001);
    press(3'b110, 16'h0004); check("R9 shl by 4", 16'h0010);
    press(3'b110, 16'h0010); check("R9 shl by 16 clears", 16'h0000);
    press(3'b011, 16'h8000);
    press(3'b111, 16'h0004); check("R9/R5 sra fills sign", 16'hf800);
    press(3'b111, 16'h0013); check("R9/R5 sra by 19", 16'hffff);
    press(3'b000, 16'hfffe); check("R6/R5 add negative", 16'hfffd);
  endtask

  task automatic t_idle();
    clear_acc();
    press(3'b011, 16'h5a5a);
    @(negedge clk);
    {pick_hi, pick_mid, pick_lo} = 3'b111;
    sw_in = 16'h0003;
    repeat (5) @(negedge clk);
    {pick_hi, pick_mid, pick_lo} = 3'b001;
    sw_in = 16'hffff;
    repeat (5) @(negedge clk);
    check("R10 idle inputs ignored", 16'h5a5a);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_hold();
    t_priority();
    t_shifts();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule